// File: doc/BRIEF.md
# Eight-bit GPIO port with peripheral pin overrides

This block is one eight-bit general-purpose I/O port. Software sets a direction bit and a port bit for every pin through a small write/read register bus. A port bit drives the pin when the pin is an output and turns on the pull-up when the pin is an input. Pin levels pass through a two-stage synchronizer. The synchronized levels can then be read over the bus and are also forwarded to the peripherals.

Several peripherals can take over individual pins: an SPI channel (master or slave), compare outputs of timers 0, 3 and 4, a divided clock output, a synchronous USART clock, and the pin-change and external interrupt inputs. For every pin the block works out the final output enable, output value, pull-up enable and digital input enable. It does this by merging the register bits with the override-enable and override-value pairs that the peripherals supply as plain input ports.

Top module: `gpio_port_ovr`

## Requirements
- R1: After reset the direction and port registers read 0. Every pin is then an input with no pull-up, except that bit 1 is driven whenever `clkout_cfg` is 1, even while `rst_n` is low.
- R2: A bus write with address 0 loads the direction register and a write with address 1 loads the port register. `rd_data` returns the direction register for address 0, the port register for 1, the synchronized pin levels for 2 and zero for 3.
- R3: A change on `pin_in` shows up on `pin_sync` and at read address 2 after two rising clock edges, and not after one.
- R4: `pin_pu[i]` is 1 exactly when the port bit is 1, `pu_off` is 0 and the pin's final output enable is 0.
- R5: With the SPI enabled as a slave, bits 7, 5 and 4 are inputs whatever their direction bits say, and their pull-ups still follow R4. Bit 6 then carries the slave data output when its direction bit is 1.
- R6: With the SPI enabled as a master, bit 6 is an input whatever its direction bit says. Bit 7 carries the SPI clock output and bit 5 carries the master data output, each only when that pin's direction bit is 1.
- R7: The value driven on bit 7 is the OR of the SPI master clock, timer 3 compare B and timer 4 compare B, each counted only while enabled. The value on bit 6 is the OR of the SPI slave data output and the enabled timer 3 compare A. Without any active override, a pin drives its port bit.
- R8: The timer 0 compare B output drives bit 4 and the compare A output drives bit 3, each when its enable is 1. A compare output reaches a pin only while that pin's direction bit is 1.
- R9: While `clkout_cfg` is 1, bit 1 is driven with `io_clk` regardless of its direction and port bits.
- R10: While `usart_sync` is 1, bit 0 carries `xck_out` when direction bit 0 is 1 and is an input when it is 0. While `usart_sync` is 0, bit 0 is an ordinary port pin.
- R11: `pin_ie[i]` is 1 when `inbuf_off` is 0, or when both `pc_mask[i]` and `pc_group_en` are 1, or for bit 2 when `ext2_en` is 1. A pin whose input enable is 0 reads as 0 after the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 direction, 1 port) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| pu_off | input | 1 | Global pull-up disable |
| inbuf_off | input | 1 | Turns input buffers off unless forced on |
| spi_en | input | 1 | SPI enabled |
| spi_master | input | 1 | SPI in master mode (else slave) |
| spi_sck_o | input | 1 | SPI master clock output |
| spi_sdo_s | input | 1 | SPI slave data output |
| spi_sdo_m | input | 1 | SPI master data output |
| t3_cb_en | input | 1 | Timer 3 compare B output enable |
| t3_cb | input | 1 | Timer 3 compare B value |
| t4_cb_en | input | 1 | Timer 4 compare B output enable |
| t4_cb | input | 1 | Timer 4 compare B value |
| t3_ca_en | input | 1 | Timer 3 compare A output enable |
| t3_ca | input | 1 | Timer 3 compare A value |
| t0_cb_en | input | 1 | Timer 0 compare B output enable |
| t0_cb | input | 1 | Timer 0 compare B value |
| t0_ca_en | input | 1 | Timer 0 compare A output enable |
| t0_ca | input | 1 | Timer 0 compare A value |
| clkout_cfg | input | 1 | Clock-out configuration |
| io_clk | input | 1 | I/O clock to present on bit 1 |
| usart_sync | input | 1 | USART in synchronous mode |
| xck_out | input | 1 | USART clock output |
| pc_mask | input | 8 | Pin-change mask per pin |
| pc_group_en | input | 1 | Pin-change group enable |
| ext2_en | input | 1 | External interrupt 2 enable |
| pin_in | input | 8 | Pad levels |
| pin_oe | output | 8 | Final output enable per pin |
| pin_out | output | 8 | Final output value per pin |
| pin_pu | output | 8 | Final pull-up enable per pin |
| pin_ie | output | 8 | Final digital input enable per pin |
| pin_sync | output | 8 | Synchronized pin levels to peripherals |

## Verification
Bit 7 is the pin where two sources meet in one cycle: the SPI master clock and the timer 3 or timer 4 compare B outputs can all be active together. The bench sets master mode and an enabled compare B in the same cycle and steps through all four value combinations. A driven value that differs from the OR of the two sources is a failure. A second meeting point is the clock output on bit 1 while reset is asserted. The bench holds reset low, toggles `io_clk` and expects bit 1 to follow it while every other pin stays undriven.

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       pu_off,
  input  logic       inbuf_off,
  input  logic       spi_en,
  input  logic       spi_master,
  input  logic       spi_sck_o,
  input  logic       spi_sdo_s,
  input  logic       spi_sdo_m,
  input  logic       t3_cb_en,
  input  logic       t3_cb,
  input  logic       t4_cb_en,
  input  logic       t4_cb,
  input  logic       t3_ca_en,
  input  logic       t3_ca,
  input  logic       t0_cb_en,
  input  logic       t0_cb,
  input  logic       t0_ca_en,
  input  logic       t0_ca,
  input  logic       clkout_cfg,
  input  logic       io_clk,
  input  logic       usart_sync,
  input  logic       xck_out,
  input  logic [7:0] pc_mask,
  input  logic       pc_group_en,
  input  logic       ext2_en,
  input  logic [7:0] pin_in,
  output logic [7:0] pin_oe,
  output logic [7:0] pin_out,
  output logic [7:0] pin_pu,
  output logic [7:0] pin_ie,
  output logic [7:0] pin_sync
);
  localparam logic [1:0] A_DIR  = 2'd0;
  localparam logic [1:0] A_PORT = 2'd1;
  localparam logic [1:0] A_PIN  = 2'd2;

  logic [7:0] dir_q, port_q, sync1_q, sync2_q;
  logic [7:0] force_in, ovr_en, ovr_val;
  logic       spi_s, spi_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      port_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_DIR)  dir_q  <= wr_data;
      if (wr_addr == A_PORT) port_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in & pin_ie;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    case (rd_addr)
      A_DIR:   rd_data = dir_q;
      A_PORT:  rd_data = port_q;
      A_PIN:   rd_data = sync2_q;
      default: rd_data = '0;
    endcase
  end

  assign spi_s = spi_en & ~spi_master;
  assign spi_m = spi_en & spi_master;

  assign force_in = {spi_s, spi_m, spi_s, spi_s, 4'b0000};

  assign ovr_en = {spi_m | t3_cb_en | t4_cb_en,
                   spi_s | t3_ca_en,
                   spi_m,
                   t0_cb_en,
                   t0_ca_en,
                   1'b0,
                   clkout_cfg,
                   usart_sync};

  assign ovr_val = {(spi_m & spi_sck_o) | (t3_cb_en & t3_cb) | (t4_cb_en & t4_cb),
                    (spi_s & spi_sdo_s) | (t3_ca_en & t3_ca),
                    spi_sdo_m,
                    t0_cb,
                    t0_ca,
                    1'b0,
                    io_clk,
                    xck_out};

  assign pin_oe   = (dir_q & ~force_in) | {6'b0, clkout_cfg, 1'b0};
  assign pin_out  = (ovr_en & ovr_val) | (~ovr_en & port_q);
  assign pin_pu   = ~pin_oe & port_q & {8{~pu_off}};
  assign pin_ie   = {8{~inbuf_off}} | (pc_mask & {8{pc_group_en}}) | {5'b0, ext2_en, 2'b0};
  assign pin_sync = sync2_q;

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_DIR) |=> (dir_q == $past(wr_data)));

  p_no_pu_on_output_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu & pin_oe) == 8'h00);

  p_slave_inputs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && !spi_master) |-> (pin_oe[7] == 1'b0 && pin_oe[5] == 1'b0 && pin_oe[4] == 1'b0));

  p_master_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && spi_master) |-> (pin_oe[6] == 1'b0));

  p_clkout_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clkout_cfg |-> (pin_oe[1] && pin_out[1] == io_clk));

  p_sync_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(pin_in & pin_ie) |=> ##1 (pin_sync == $past(pin_in & pin_ie, 2)) or !$stable(pin_in & pin_ie));
endmodule

// File: tb/test_gpio_port_ovr.sv
module test_gpio_port_ovr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic pu_off = 0, inbuf_off = 0, spi_en = 0, spi_master = 0;
  logic spi_sck_o = 0, spi_sdo_s = 0, spi_sdo_m = 0;
  logic t3_cb_en = 0, t3_cb = 0, t4_cb_en = 0, t4_cb = 0, t3_ca_en = 0, t3_ca = 0;
  logic t0_cb_en = 0, t0_cb = 0, t0_ca_en = 0, t0_ca = 0;
  logic clkout_cfg = 0, io_clk = 0, usart_sync = 0, xck_out = 0;
  logic [7:0] pc_mask = '0;
  logic pc_group_en = 0, ext2_en = 0;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_oe, pin_out, pin_pu, pin_ie, pin_sync;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_port_ovr i_gpio_port_ovr (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .pu_off, .inbuf_off, .spi_en, .spi_master, .spi_sck_o, .spi_sdo_s, .spi_sdo_m,
    .t3_cb_en, .t3_cb, .t4_cb_en, .t4_cb, .t3_ca_en, .t3_ca,
    .t0_cb_en, .t0_cb, .t0_ca_en, .t0_ca,
    .clkout_cfg, .io_clk, .usart_sync, .xck_out,
    .pc_mask, .pc_group_en, .ext2_en,
    .pin_in, .pin_oe, .pin_out, .pin_pu, .pin_ie, .pin_sync
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    #1;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic t_reset();
    clkout_cfg = 1; io_clk = 1; #1;
    chk("R1 clkout oe in reset", pin_oe, 8'h02);
    chk("R9 clkout value in reset", pin_out & 8'h02, 8'h02);
    io_clk = 0; #1;
    chk("R9 clkout follows io_clk in reset", pin_out & 8'h02, 8'h00);
    clkout_cfg = 0; #1;
    chk("R1 no drive in reset", pin_oe, 8'h00);
    chk("R1 no pullup in reset", pin_pu, 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1;
    settle();
    rd_chk("R1 dir reset", 2'd0, 8'h00);
    rd_chk("R1 port reset", 2'd1, 8'h00);
  endtask

  task automatic t_bus();
    wr(2'd0, 8'hA5);
    wr(2'd1, 8'h3C);
    rd_chk("R2 dir readback", 2'd0, 8'hA5);
    rd_chk("R2 port readback", 2'd1, 8'h3C);
    rd_chk("R2 addr3 zero", 2'd3, 8'h00);
    chk("R7 port drives outputs", pin_out & pin_oe, 8'h3C & 8'hA5);
    chk("R4 pullups on inputs", pin_pu, 8'h3C & ~8'hA5);
    pu_off = 1; #1;
    chk("R4 global pullup disable", pin_pu, 8'h00);
    pu_off = 0;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_sync();
    @(negedge clk);
    pin_in = 8'h96;
    @(negedge clk); #1;
    rd_chk("R3 not visible after one edge", 2'd2, 8'h00);
    @(negedge clk); #1;
    rd_chk("R3 visible after two edges", 2'd2, 8'h96);
    chk("R3 forwarded to peripherals", pin_sync, 8'h96);
  endtask

  task automatic t_inen();
    inbuf_off = 1; pc_mask = 8'h81; pc_group_en = 0; ext2_en = 0; #1;
    chk("R11 all off", pin_ie, 8'h00);
    pc_group_en = 1; #1;
    chk("R11 pin change forces", pin_ie, 8'h81);
    ext2_en = 1; #1;
    chk("R11 ext2 forces bit2", pin_ie, 8'h85);
    pin_in = 8'hFF;
    repeat (3) @(negedge clk); #1;
    rd_chk("R11 disabled inputs read 0", 2'd2, 8'h85);
    inbuf_off = 0; pc_mask = 0; pc_group_en = 0; ext2_en = 0; pin_in = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_spi_slave();
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'hB0);
    spi_en = 1; spi_master = 0; spi_sdo_s = 1; #1;
    chk("R5 slave forces 7,5,4 input", pin_oe, 8'h4F);
    chk("R5 pullup kept on forced pins", pin_pu, 8'hB0);
    chk("R5 slave data out on bit6", pin_out & 8'h40, 8'h40);
    spi_sdo_s = 0; #1;
    chk("R5 slave data low", pin_out & 8'h40, 8'h00);
    spi_en = 0;
    wr(2'd1, 8'h00);
  endtask

  task automatic t_spi_master();
    spi_en = 1; spi_master = 1; spi_sck_o = 1; spi_sdo_m = 1; #1;
    chk("R6 master forces bit6 input", pin_oe, 8'hBF);
    chk("R6 sck and mosi driven", pin_out & 8'hA0, 8'hA0);
    spi_sck_o = 0; spi_sdo_m = 0; #1;
    chk("R6 sck and mosi low", pin_out & 8'hA0, 8'h00);
    wr(2'd0, 8'h5F);
    chk("R6 bits follow dir bits", pin_oe, 8'h1F);
    wr(2'd0, 8'hFF);
  endtask

  task automatic t_collide();
    t3_cb_en = 1;
    for (int k = 0; k < 4; k++) begin
      spi_sck_o = k[0]; t3_cb = k[1]; #1;
      chk("R7 bit7 OR of sck and t3 cmpB", {7'b0, pin_out[7]}, {7'b0, k[0] | k[1]});
    end
    spi_en = 0; spi_master = 0; spi_sck_o = 0; t3_cb = 0; t3_cb_en = 0;
    t4_cb_en = 1; t4_cb = 1; #1;
    chk("R7 t4 cmpB on bit7", {7'b0, pin_out[7]}, 8'h01);
    t4_cb_en = 0; t4_cb = 0;
    t3_ca_en = 1; t3_ca = 1; #1;
    chk("R7 t3 cmpA on bit6", {7'b0, pin_out[6]}, 8'h01);
    t3_ca_en = 0; t3_ca = 0; #1;
    chk("R7 no override drives port bits", pin_out, 8'h00);
  endtask

  task automatic t_timer0();
    t0_cb_en = 1; t0_ca_en = 1; t0_cb = 1; t0_ca = 0; #1;
    chk("R8 t0 cmp on bits4,3", pin_out & 8'h18, 8'h10);
    wr(2'd0, 8'hE7);
    chk("R8 cmp blocked when dir 0", pin_oe & 8'h18, 8'h00);
    t0_cb_en = 0; t0_ca_en = 0; t0_cb = 0;
  endtask

  task automatic t_clkout();
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h02);
    clkout_cfg = 1; io_clk = 1; #1;
    chk("R9 bit1 driven with dir 0", pin_oe, 8'h02);
    chk("R9 bit1 carries io_clk", pin_out & 8'h02, 8'h02);
    chk("R4 no pullup on clkout pin", pin_pu, 8'h00);
    clkout_cfg = 0; io_clk = 0;
    wr(2'd1, 8'h00);
  endtask

  task automatic t_usart();
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h01);
    usart_sync = 1; xck_out = 0; #1;
    chk("R10 xck drives bit0", pin_out & 8'h01, 8'h00);
    xck_out = 1; #1;
    chk("R10 xck high", pin_out & 8'h01, 8'h01);
    wr(2'd0, 8'h00);
    chk("R10 dir0 0 makes clock input", pin_oe, 8'h00);
    wr(2'd0, 8'h01);
    usart_sync = 0; xck_out = 0; wr(2'd1, 8'h00);
    chk("R10 async bit0 is port pin", pin_out & 8'h01, 8'h00);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_bus();
    t_sync();
    t_inen();
    t_spi_slave();
    t_spi_master();
    t_collide();
    t_timer0();
    t_clkout();
    t_usart();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule